// File: doc/BRIEF.md
# HDLC Bit-Stuffing Transmit Framer

This block turns a sequence of bytes, offered one at a time by a parallel back-end, into a serial HDLC line signal. One bit leaves per cycle of the transmit clock, which is supplied from outside the block. Each frame is wrapped in flag octets. Inside the frame body a zero is inserted after every run of five ones, so the body can never look like a flag. Frame check bytes and address bytes come from the back-end as ordinary payload.

The back-end holds `frm_active` high for the whole frame and `byte_valid` high whenever a byte waits on `byte_data`. The framer pulses `byte_take` in the same cycle as the final bit of the current byte, so the next byte follows with no gap. When `frm_active` is low at a byte boundary, the framer sends a closing flag. It then keeps sending flags until the next frame. The back-end can end a frame early with `abort_req`. If `frm_active` is high but no byte is ready at a byte boundary (an underrun), the framer aborts the frame by itself. After an abort the line rests at all ones. The same is true after reset.

The controller has six states. IDLE sends ones. OPEN sends the opening flag. DATA sends payload bits and inserted zeros. CLOSE sends the closing flag. FILL repeats flags between frames. ABORT sends the abort octet. The transitions are as follows:
- IDLE goes to OPEN when a frame and a byte are offered.
- OPEN goes to DATA and takes the first byte.
- OPEN goes to ABORT on an abort request or an underrun.
- OPEN goes to FILL for an empty frame.
- DATA stays in DATA at a byte boundary when the next byte is taken.
- DATA goes to CLOSE at the end of the frame.
- DATA goes to ABORT on an abort request or an underrun.
- CLOSE goes to FILL.
- FILL goes to DATA when a new frame's first byte is taken. The last fill flag serves as the opening flag.
- ABORT goes to IDLE.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst_n` is low, and from reset until the first frame starts, `ser_out` is 1 and `byte_take` is 0. Reset is asynchronous and active low.
- R2: The first payload bit is preceded directly by a flag octet 0,1,1,1,1,1,1,0.
- R3: Each byte is sent least significant bit first. Consecutive bytes of a frame follow each other with no idle bits, and there is one `byte_take` pulse per byte.
- R4: Inside the frame body, a 0 follows every five consecutive 1s. The run count restarts after a sent 0 or an inserted 0, carries across byte boundaries, and produces an inserted 0 after a byte's last bit before the closing flag. The body never carries six 1s in a row.
- R5: When `frm_active` is low at the end of a byte, a closing flag octet follows the body directly.
- R6: After a frame that ended normally, the line carries back-to-back flag octets and never idle ones.
- R7: When `abort_req` is high in a cycle of state OPEN or DATA, the next bit is 0, the seven bits after it are 1, no zero is inserted, and no byte is taken.
- R8: When `frm_active` is high but `byte_valid` is low at a byte boundary (including the end of the opening flag), the framer sends 0 followed by seven 1s instead of waiting.
- R9: After an abort octet the line carries continuous 1s until a new frame starts. ABORT leads only to IDLE, and IDLE only to IDLE or OPEN.
- R10: `abort_req` has no effect in states IDLE, CLOSE and FILL. In particular, the flag stream between frames continues unchanged.
- R11: `byte_take` is high only when `frm_active` and `byte_valid` are both high, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | External transmit bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_active | input | 1 | Back-end marks a frame in progress |
| byte_valid | input | 1 | A byte waits on byte_data |
| byte_data | input | 8 | Payload byte, bit 0 is sent first |
| abort_req | input | 1 | Request to abort the current frame |
| byte_take | output | 1 | Byte on byte_data is consumed at this clock edge |
| ser_out | output | 1 | Serial line output, registered |

## Verification
The assertions check several rules on every cycle: no body bit extends a run of ones past five, the consume strobe is qualified and spaced, IDLE always yields ones, and the abort and idle states move only along their allowed edges. Other behaviour is visible only in whole bit sequences, so only the bench's scenarios can show it. This covers flag placement around the body, least-significant-bit-first order without gaps, the exact position of an inserted zero at a byte end, the abort octet that follows an underrun or a request, and abort requests being ignored between frames. The bench compares the captured line against streams that it builds itself from the payload.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    // Controller states of the transmit framer
    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_OPEN  = 3'd1,
        TX_DATA  = 3'd2,
        TX_CLOSE = 3'd3,
        TX_FILL  = 3'd4,
        TX_ABORT = 3'd5
    } tx_state_e;

endpackage

// File: rtl/hdlc_tx_pattern.sv
// Fixed octet patterns: flag in OPEN/CLOSE/FILL, abort octet, idle ones.
module hdlc_tx_pattern
    import hdlc_tx_pkg::*;
#(
    parameter int              PAT_W    = 8,
    parameter logic [PAT_W-1:0] FLAG_PAT = 'h7E,
    localparam int             SEL_W    = $clog2(PAT_W)
) (
    input  tx_state_e        st,
    input  logic [SEL_W-1:0] pos,
    output logic             pat_bit
);

    always_comb begin
        unique case (st)
            TX_OPEN, TX_CLOSE, TX_FILL: pat_bit = FLAG_PAT[pos];
            TX_ABORT:                   pat_bit = (pos != '0);  // R7 R8: 0 then ones
            default:                    pat_bit = 1'b1;         // R1 R9: idle ones
        endcase
    end

endmodule

// File: rtl/hdlc_tx_stuffer.sv
// Counts consecutive body ones and flags when a zero must be inserted (R4).
module hdlc_tx_stuffer #(
    parameter int  RUN_MAX = 5,
    localparam int CNT_W   = $clog2(RUN_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_clr,
    input  logic bit_sent,
    input  logic bit_val,
    input  logic stuff_sent,
    output logic need_stuff,
    output logic near_limit
);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (run_clr || stuff_sent) begin
            run_q <= '0;
        end else if (bit_sent) begin
            run_q <= bit_val ? run_q + CNT_W'(1) : '0;
        end
    end

    assign need_stuff = (run_q == CNT_W'(RUN_MAX));
    assign near_limit = (run_q == CNT_W'(RUN_MAX - 1));

endmodule

// File: rtl/hdlc_tx_fsm.sv
// Framer controller: state register in one process, transitions and outputs in another.
module hdlc_tx_fsm
    import hdlc_tx_pkg::*;
#(
    parameter int  DATA_W = 8,
    localparam int SEL_W  = $clog2(DATA_W),
    localparam int IDX_W  = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_active,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              abort_req,
    input  logic              need_stuff,
    input  logic              near_limit,
    input  logic              pat_bit,
    output tx_state_e         st_q,
    output logic [SEL_W-1:0]  pos,
    output logic              byte_take,
    output logic              run_clr,
    output logic              bit_sent,
    output logic              bit_val,
    output logic              stuff_sent,
    output logic              ser_out
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_TAIL = IDX_W'(DATA_W);  // only an inserted zero left

    tx_state_e         st_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [DATA_W-1:0] sh_q, sh_n;
    logic              ser_q, bit_n;
    logic              at_last, cur_bit, byte_end, load;

    assign pos     = idx_q[SEL_W-1:0];
    assign at_last = (idx_q == IDX_LAST);
    assign cur_bit = sh_q[idx_q[SEL_W-1:0]];   // R3: LSB first
    assign ser_out = ser_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            idx_q <= '0;
            sh_q  <= '0;
            ser_q <= 1'b1;                      // R1
        end else begin
            st_q  <= st_n;
            idx_q <= idx_n;
            sh_q  <= sh_n;
            ser_q <= bit_n;
        end
    end

    // Transitions and outputs
    always_comb begin
        st_n       = st_q;
        idx_n      = idx_q;
        sh_n       = sh_q;
        bit_n      = pat_bit;
        byte_take  = 1'b0;
        run_clr    = 1'b0;
        bit_sent   = 1'b0;
        bit_val    = 1'b0;
        stuff_sent = 1'b0;
        byte_end   = 1'b0;
        load       = 1'b0;

        unique case (st_q)
            TX_IDLE: begin
                if (frm_active && byte_valid) begin
                    st_n  = TX_OPEN;
                    idx_n = '0;
                end
            end
            TX_OPEN: begin
                if (abort_req) begin            // R7
                    bit_n = 1'b0;
                    st_n  = TX_ABORT;
                    idx_n = IDX_W'(1);
                end else if (at_last) begin
                    idx_n = '0;
                    if (frm_active && byte_valid) load = 1'b1;
                    else if (frm_active)          st_n = TX_ABORT;  // R8
                    else                          st_n = TX_FILL;
                end else begin
                    idx_n = idx_q + IDX_W'(1);
                end
            end
            TX_FILL: begin                      // R10: abort_req not looked at
                if (at_last) begin
                    idx_n = '0;
                    if (frm_active && byte_valid) load = 1'b1;
                end else begin
                    idx_n = idx_q + IDX_W'(1);
                end
            end
            TX_CLOSE: begin
                if (at_last) begin
                    idx_n = '0;
                    st_n  = TX_FILL;            // R6
                end else begin
                    idx_n = idx_q + IDX_W'(1);
                end
            end
            TX_DATA: begin
                if (abort_req) begin            // R7
                    bit_n = 1'b0;
                    st_n  = TX_ABORT;
                    idx_n = IDX_W'(1);
                end else if (need_stuff) begin  // R4
                    bit_n      = 1'b0;
                    stuff_sent = 1'b1;
                    if (idx_q == IDX_TAIL) byte_end = 1'b1;
                    else                   idx_n    = idx_q;
                end else begin
                    bit_n    = cur_bit;
                    bit_sent = 1'b1;
                    bit_val  = cur_bit;
                    if (at_last) begin
                        if (cur_bit && near_limit) idx_n    = IDX_TAIL;
                        else                       byte_end = 1'b1;
                    end else begin
                        idx_n = idx_q + IDX_W'(1);
                    end
                end
            end
            TX_ABORT: begin
                if (at_last) begin
                    idx_n = '0;
                    st_n  = TX_IDLE;            // R9
                end else begin
                    idx_n = idx_q + IDX_W'(1);
                end
            end
            default: begin
                st_n  = TX_IDLE;
                idx_n = '0;
            end
        endcase

        if (byte_end) begin
            idx_n = '0;
            if (frm_active && byte_valid) load = 1'b1;     // R3
            else if (frm_active)          st_n = TX_ABORT; // R8
            else                          st_n = TX_CLOSE; // R5
        end

        if (load) begin                                    // R11
            byte_take = 1'b1;
            sh_n      = byte_data;
            st_n      = TX_DATA;
            idx_n     = '0;
            run_clr   = (st_q != TX_DATA);
        end
    end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RUN_MAX = 5
) (
    input  logic              clk_tx,
    input  logic              rst_n,
    input  logic              frm_active,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              abort_req,
    output logic              byte_take,
    output logic              ser_out
);

    localparam int SEL_W = $clog2(DATA_W);

    tx_state_e        fsm_state;
    logic [SEL_W-1:0] pat_pos;
    logic             pat_bit, need_stuff, near_limit;
    logic             run_clr, bit_sent, bit_val, stuff_sent;

    hdlc_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk_tx),
        .rst_n      (rst_n),
        .frm_active (frm_active),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .abort_req  (abort_req),
        .need_stuff (need_stuff),
        .near_limit (near_limit),
        .pat_bit    (pat_bit),
        .st_q       (fsm_state),
        .pos        (pat_pos),
        .byte_take  (byte_take),
        .run_clr    (run_clr),
        .bit_sent   (bit_sent),
        .bit_val    (bit_val),
        .stuff_sent (stuff_sent),
        .ser_out    (ser_out)
    );

    hdlc_tx_pattern #(.PAT_W(DATA_W), .FLAG_PAT(DATA_W'('h7E))) u_pat (
        .st      (fsm_state),
        .pos     (pat_pos),
        .pat_bit (pat_bit)
    );

    hdlc_tx_stuffer #(.RUN_MAX(RUN_MAX)) u_stuff (
        .clk        (clk_tx),
        .rst_n      (rst_n),
        .run_clr    (run_clr),
        .bit_sent   (bit_sent),
        .bit_val    (bit_val),
        .stuff_sent (stuff_sent),
        .need_stuff (need_stuff),
        .near_limit (near_limit)
    );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
    import hdlc_tx_pkg::*;
#(
    parameter int RUN_MAX = 5
) (
    input logic      clk,
    input logic      rst_n,
    input logic      frm_active,
    input logic      byte_valid,
    input logic      byte_take,
    input logic      ser_out,
    input tx_state_e st
);

    logic [3:0] ones_run_q;   // ones on the line before the current bit
    logic       from_data_q;  // current line bit was produced in DATA

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_run_q  <= '0;
            from_data_q <= 1'b0;
        end else begin
            ones_run_q  <= ser_out ? ((ones_run_q == 4'd15) ? ones_run_q : ones_run_q + 4'd1) : 4'd0;
            from_data_q <= (st == TX_DATA);
        end
    end

    assert_stuff_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (from_data_q && ser_out) |-> (ones_run_q < 4'(RUN_MAX)));

    assert_take_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> (frm_active && byte_valid));

    assert_take_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |=> !byte_take);

    assert_idle_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE) |=> ser_out);

    assert_abort_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_ABORT) |=> (st == TX_ABORT || st == TX_IDLE));

    assert_idle_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE) |=> (st == TX_IDLE || st == TX_OPEN));

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.RUN_MAX(RUN_MAX)) u_chk (
    .clk        (clk_tx),
    .rst_n      (rst_n),
    .frm_active (frm_active),
    .byte_valid (byte_valid),
    .byte_take  (byte_take),
    .ser_out    (ser_out),
    .st         (fsm_state)
);

// File: tb/tb_hdlc_tx_framer.sv
`timescale 1ns/1ps
module tb_hdlc_tx_framer;

    localparam int CAP_N = 16384;
    localparam logic [7:0] FLAG = 8'h7E;

    logic       clk_tx = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_active = 1'b0;
    logic       byte_valid = 1'b0;
    logic       abort_req = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_take;
    logic       ser_out;

    always #2.5 clk_tx = ~clk_tx;

    hdlc_tx_framer dut (
        .clk_tx     (clk_tx),
        .rst_n      (rst_n),
        .frm_active (frm_active),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .abort_req  (abort_req),
        .byte_take  (byte_take),
        .ser_out    (ser_out)
    );

    int   n_chk = 0, n_bad = 0;
    bit   cap_bit [CAP_N];
    bit   cap_take[CAP_N];
    int   ncap = 0;
    logic [7:0] pay[64];
    int   len = 0, pos = 0, ur_pos = -1;
    bit   take_seen = 1'b0, abort_pend = 1'b0;
    bit   expv[2048];
    int   nexp = 0;

    task automatic tick();
        @(negedge clk_tx);
        if (take_seen) pos++;
        frm_active = (pos < len);
        byte_valid = (pos < len) && (ur_pos < 0 || pos < ur_pos);
        byte_data  = (pos < len) ? pay[pos] : 8'h00;
        abort_req  = abort_pend;
        #1;
        if (ncap < CAP_N) begin
            cap_bit[ncap]  = ser_out;
            cap_take[ncap] = byte_take;
        end
        take_seen = byte_take;
        ncap++;
    endtask

    task automatic check(bit ok, string req, string what, int act, int expd);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expd);
        end
    endtask

    task automatic exp_push(bit b);
        expv[nexp] = b;
        nexp++;
    endtask

    task automatic exp_flag();
        for (int i = 0; i < 8; i++) exp_push(FLAG[i]);
    endtask

    // reference zero insertion over pay[0..cnt-1], LSB first
    task automatic exp_payload(int cnt);
        int ones = 0;
        for (int j = 0; j < cnt; j++) begin
            for (int i = 0; i < 8; i++) begin
                exp_push(pay[j][i]);
                ones = pay[j][i] ? ones + 1 : 0;
                if (ones == 5) begin
                    exp_push(1'b0);
                    ones = 0;
                end
            end
        end
    endtask

    task automatic compare_at(int start, string req, string what);
        int bad = -1;
        for (int i = 0; i < nexp; i++)
            if (bad < 0 && (start + i < 0 || start + i >= ncap || cap_bit[start + i] != expv[i])) bad = i;
        if (bad < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, {what, " first differing bit index as actual"}, bad, nexp);
    endtask

    function automatic int find_take(int from);
        for (int i = from; i < ncap; i++) if (cap_take[i]) return i;
        return -1;
    endfunction

    function automatic int count_take(int from, int upto);
        int c = 0;
        for (int i = from; i < upto; i++) if (cap_take[i]) c++;
        return c;
    endfunction

    function automatic logic [7:0] pick_byte();
        case ($urandom_range(0, 3))
            0: return 8'hFF;
            1: return 8'h7E;
            2: return 8'hF8;
            default: return 8'($urandom);
        endcase
    endfunction

    // normal frame: flag, stuffed body, closing flag, two fill flags
    task automatic send_frame(int L, string what);
        int s = ncap;
        int k0;
        int guard = 0;
        len = L; pos = 0; ur_pos = -1;
        while (pos < len && guard < 4000) begin tick(); guard++; end
        repeat (L * 10 + 40) tick();
        len = 0;
        k0 = find_take(s);
        check(k0 >= 6, "R2", {what, " first take index"}, k0, 6);
        nexp = 0;
        exp_flag(); exp_payload(L); exp_flag(); exp_flag(); exp_flag();
        compare_at(k0 - 6, "R2 R3 R4 R5 R6", what);
        check(count_take(s, ncap) == L, "R3 R11", {what, " take count"}, count_take(s, ncap), L);
    endtask

    initial begin
        int m, s, k0, guard;
        bit per_ok;
        void'($urandom(32'd4242));

        // R1: reset state
        repeat (3) tick();
        check(ser_out == 1'b1, "R1", "line during reset", ser_out, 1);
        check(byte_take == 1'b0, "R1", "take during reset", byte_take, 0);
        rst_n = 1'b1;
        s = ncap;
        repeat (12) tick();
        check(count_take(s, ncap) == 0, "R1", "take after reset", count_take(s, ncap), 0);
        per_ok = 1'b1;
        for (int i = s; i < ncap; i++) if (!cap_bit[i]) per_ok = 1'b0;
        check(per_ok, "R1", "idle ones after reset", per_ok, 1);

        // directed corner frames
        pay[0] = 8'hF8; send_frame(1, "R4 stuff at byte end");
        pay[0] = 8'hFF; pay[1] = 8'hFF; send_frame(2, "R4 run across bytes");
        pay[0] = 8'h7E; pay[1] = 8'h7E; send_frame(2, "R4 flag-like payload");
        pay[0] = 8'h1F; pay[1] = 8'hF8; pay[2] = 8'h3E; send_frame(3, "R3 mixed");
        pay[0] = 8'h00; send_frame(1, "R3 single zero byte");

        // R10: abort request between frames is ignored
        repeat (5) tick();
        abort_pend = 1'b1; tick(); abort_pend = 1'b0;
        s = ncap;
        repeat (24) tick();
        per_ok = 1'b1;
        for (int i = s + 8; i < ncap; i++) if (cap_bit[i] != cap_bit[i - 8]) per_ok = 1'b0;
        if (count_take(s, ncap) != 0) per_ok = 1'b0;
        check(per_ok, "R10", "flags continue after ignored abort", per_ok, 1);

        // R8: underrun after two bytes
        for (int j = 0; j < 4; j++) pay[j] = pick_byte();
        s = ncap; len = 4; pos = 0; ur_pos = 2; guard = 0;
        while (pos < 2 && guard < 4000) begin tick(); guard++; end
        repeat (50) tick();
        len = 0; ur_pos = -1;
        k0 = find_take(s);
        nexp = 0;
        exp_flag(); exp_payload(2); exp_push(1'b0);
        repeat (7) exp_push(1'b1);
        repeat (16) exp_push(1'b1);
        compare_at(k0 - 6, "R8 R9", "underrun abort then idle");
        check(count_take(s, ncap) == 2, "R8", "takes before underrun", count_take(s, ncap), 2);

        // R7: abort request inside the body, from idle start
        for (int j = 0; j < 8; j++) pay[j] = pick_byte();
        s = ncap; len = 8; pos = 0; guard = 0;
        while (pos < 2 && guard < 4000) begin tick(); guard++; end
        repeat (3) tick();
        abort_pend = 1'b1; len = 0;
        m = ncap;
        tick();
        abort_pend = 1'b0;
        repeat (30) tick();
        k0 = find_take(s);
        nexp = 0;
        exp_flag(); exp_payload(8);
        nexp = m - (k0 - 6) + 1;
        exp_push(1'b0);
        repeat (7) exp_push(1'b1);
        repeat (16) exp_push(1'b1);
        compare_at(k0 - 6, "R7 R9", "requested abort");
        check(count_take(m, ncap) == 0, "R7", "takes after abort", count_take(m, ncap), 0);

        // random frames with a fixed seed
        for (int f = 0; f < 30; f++) begin
            int L = $urandom_range(1, 6);
            for (int j = 0; j < L; j++) pay[j] = pick_byte();
            send_frame(L, "R3 R4 random frame");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule